// File: doc/BRIEF.md
# Task-Switched Page Mapper

This block turns the 16-bit addresses of an 8-bit CPU into 20-bit physical addresses. The top four address bits pick one of sixteen 4 KB pages. The mapper joins them with a 7-bit task number to look up an 8-bit physical page number in a 2048-entry translation table. The low twelve address bits pass through unchanged as the offset within the page. The lookup is combinational, so the mapped address is valid in the same cycle as the CPU address.

The task number comes from one of four stored task slots: system, user, DMA source and DMA destination. Which slot drives the lookup is decided in hardware. Taking an interrupt switches to the system slot. Finishing a return-from-interrupt switches back to the user slot. A DMA phase input overrides both and selects the source or destination slot for as long as it is asserted. The top bit of each slot does not take part in translation. It is brought out as a flag that later write-protect logic can use.

A register port gives the CPU read and write access to the table, the four slots and an enable bit. The port is separate from the translation path, so translation keeps running while the port is used. Until the enable bit is set, every page maps to physical page 0xFF.

Top module: `task_page_mapper`

## Requirements
- R1: `phys_addr[11:0]` always equals `cpu_addr[11:0]` in the same cycle.
- R2: In the first cycle after reset the enable bit is 0, all four slots read 0, the system slot is the context, and `phys_addr[19:12]` is 0xFF.
- R3: While the enable bit is 0, `phys_addr[19:12]` is 0xFF for every address and task.
- R4: While the enable bit is 1, `phys_addr[19:12]` equals table entry {active_task[6:0], cpu_addr[15:12]} in the same cycle.
- R5: A cycle with `irq_take` high makes the system slot (slot 0) the context from the next cycle on.
- R6: A cycle with `rti_done` high and `irq_take` low makes the user slot (slot 1) the context from the next cycle on. When both are high, `irq_take` wins.
- R7: The active slot follows `dma_phase` in the same cycle: 2'b01 selects the DMA source slot (slot 2), 2'b10 selects the DMA destination slot (slot 3), and 2'b00 or 2'b11 selects the context slot.
- R8: Register port map. With `cfg_tbl`=1, `cfg_addr` addresses table entry {task[6:0], page[3:0]}. With `cfg_tbl`=0, `cfg_addr` 0..3 addresses slots 0..3, and `cfg_addr` 4 is the control register with enable in bit 0, which reads as {7'b0, enable}. Other control addresses read 0 and ignore writes.
- R9: A write on the register port is stored at the clock edge. From the next cycle on it shows on `cfg_rdata` and in translation.
- R10: Bit 7 of the active slot does not affect translation. It appears on `wp_flag` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU logical address |
| irq_take | input | 1 | Interrupt being taken this cycle |
| rti_done | input | 1 | Return from interrupt completing this cycle |
| dma_phase | input | 2 | 01 DMA source, 10 DMA destination, else none |
| cfg_tbl | input | 1 | Register port targets the table (1) or the control space (0) |
| cfg_addr | input | 11 | Register port address |
| cfg_we | input | 1 | Register port write strobe |
| cfg_wdata | input | 8 | Register port write data |
| cfg_rdata | output | 8 | Register port read data (combinational) |
| phys_addr | output | 20 | Physical address {page, offset} |
| wp_flag | output | 1 | Reserved bit 7 of the active slot |

## Verification
Translation, slot selection by `dma_phase`, `wp_flag` and register reads are combinational. The bench therefore checks them 1 ns after it drives the inputs on the falling edge, in the same cycle. Register-port writes, `irq_take` and `rti_done` act at the next rising edge. The bench updates its reference model just after that edge, so their effects are expected from the following cycle on. The reset state is checked in the first cycle after `rst_n` rises.

// File: rtl/mapper_pkg.sv
// Shared types for the task page mapper.
// Assumes: two CPU contexts only; DMA slot choice is a combinational override.
package mapper_pkg;
    typedef enum logic {CTX_SYS = 1'b0, CTX_USER = 1'b1} ctx_e;
    localparam int NUM_SLOTS  = 4;
    localparam int SLOT_SYS   = 0;
    localparam int SLOT_USER  = 1;
    localparam int SLOT_SRC   = 2;
    localparam int SLOT_DST   = 3;
    localparam logic [1:0] DMA_SRC = 2'b01;
    localparam logic [1:0] DMA_DST = 2'b10;
endpackage

// File: rtl/map_table.sv
// Translation table with one asynchronous lookup port and one config port.
// The config port writes synchronously and reads asynchronously.
// Assumes: contents are not reset; software fills entries before enabling.
module map_table #(
    parameter int IDX_W  = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  xlat_idx,
    output logic [DATA_W-1:0] xlat_data,
    output logic [DATA_W-1:0] cfg_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // store a config write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // both reads are combinational
    assign xlat_data = mem[xlat_idx];
    assign cfg_data  = mem[waddr];

    // R9
    // table_write_chk: a stored entry reads back on the next cycle
    table_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/task_slots.sv
// Holds four task slots and the CPU context.
// Picks the active slot from the context and the DMA phase.
// Assumes: irq_take has priority over rti_done.
module task_slots
    import mapper_pkg::*;
#(
    parameter int TASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_take,
    input  logic              rti_done,
    input  logic [1:0]        dma_phase,
    input  logic              slot_we,
    input  logic [1:0]        slot_idx,
    input  logic [TASK_W-1:0] slot_wdata,
    output logic [TASK_W-1:0] slot_rd,
    output logic [TASK_W-1:0] active_task
);
    logic [TASK_W-1:0] slot_q [NUM_SLOTS];
    ctx_e              ctx_q;
    logic [1:0]        act_idx;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // one task slot register, loaded from the config port
        always_ff @(posedge clk) begin
            if (!rst_n)                               slot_q[g] <= '0;
            else if (slot_we && slot_idx == 2'(g))    slot_q[g] <= slot_wdata;
        end
    end

    // context: interrupts force system, return restores user
    always_ff @(posedge clk) begin
        if (!rst_n)        ctx_q <= CTX_SYS;
        else if (irq_take) ctx_q <= CTX_SYS;
        else if (rti_done) ctx_q <= CTX_USER;
    end

    // DMA phase overrides the context choice
    always_comb begin
        unique case (dma_phase)
            DMA_SRC: act_idx = 2'(SLOT_SRC);
            DMA_DST: act_idx = 2'(SLOT_DST);
            default: act_idx = (ctx_q == CTX_USER) ? 2'(SLOT_USER) : 2'(SLOT_SYS);
        endcase
    end

    assign active_task = slot_q[act_idx];
    assign slot_rd     = slot_q[slot_idx];

    // R5
    // irq_sys_chk
    irq_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (ctx_q == CTX_SYS));
    // R6
    // rti_user_chk
    rti_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_done && !irq_take) |=> (ctx_q == CTX_USER));
    // R2
    // ctx_reset_chk
    ctx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctx_q == CTX_SYS && slot_q[0] == '0 && slot_q[3] == '0));
endmodule

// File: rtl/task_page_mapper.sv
// Top of the task page mapper: control register, register-port decode,
// read mux and physical address assembly.
// Assumes: task slot width equals page number width (shared config data bus).
module task_page_mapper #(
    parameter int VA_W       = 16,
    parameter int PAGE_BITS  = 4,
    parameter int DATA_W     = 8,
    parameter int TASK_IDX_W = 7,
    parameter logic [DATA_W-1:0] DEFAULT_PPN = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [VA_W-1:0]             cpu_addr,
    input  logic                        irq_take,
    input  logic                        rti_done,
    input  logic [1:0]                  dma_phase,
    input  logic                        cfg_tbl,
    input  logic [TASK_IDX_W+PAGE_BITS-1:0] cfg_addr,
    input  logic                        cfg_we,
    input  logic [DATA_W-1:0]           cfg_wdata,
    output logic [DATA_W-1:0]           cfg_rdata,
    output logic [DATA_W+VA_W-PAGE_BITS-1:0] phys_addr,
    output logic                        wp_flag
);
    localparam int OFF_W    = VA_W - PAGE_BITS;
    localparam int IDX_W    = TASK_IDX_W + PAGE_BITS;
    localparam int CTRL_ADR = 4;

    logic              en_q;
    logic [DATA_W-1:0] active_task;
    logic [DATA_W-1:0] slot_rd;
    logic [DATA_W-1:0] xlat_data;
    logic [DATA_W-1:0] tbl_rd;
    logic [IDX_W-1:0]  xlat_idx;
    logic              slot_we;
    logic              ctrl_hit;
    logic [DATA_W-1:0] ppn;

    assign slot_we  = cfg_we && !cfg_tbl && (cfg_addr < IDX_W'(4));
    assign ctrl_hit = !cfg_tbl && (cfg_addr == IDX_W'(CTRL_ADR));

    // enable bit in the control register
    always_ff @(posedge clk) begin
        if (!rst_n)                 en_q <= 1'b0;
        else if (cfg_we && ctrl_hit) en_q <= cfg_wdata[0];
    end

    task_slots #(.TASK_W(DATA_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_take   (irq_take),
        .rti_done   (rti_done),
        .dma_phase  (dma_phase),
        .slot_we    (slot_we),
        .slot_idx   (cfg_addr[1:0]),
        .slot_wdata (cfg_wdata),
        .slot_rd    (slot_rd),
        .active_task(active_task)
    );

    assign xlat_idx = {active_task[TASK_IDX_W-1:0], cpu_addr[VA_W-1 -: PAGE_BITS]};

    map_table #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we && cfg_tbl),
        .waddr    (cfg_addr),
        .wdata    (cfg_wdata),
        .xlat_idx (xlat_idx),
        .xlat_data(xlat_data),
        .cfg_data (tbl_rd)
    );

    // gate the table output until enabled
    assign ppn       = en_q ? xlat_data : DEFAULT_PPN;
    assign phys_addr = {ppn, cpu_addr[OFF_W-1:0]};
    assign wp_flag   = active_task[DATA_W-1];

    // register port read mux
    always_comb begin
        if (cfg_tbl)                     cfg_rdata = tbl_rd;
        else if (cfg_addr < IDX_W'(4))   cfg_rdata = slot_rd;
        else if (ctrl_hit)               cfg_rdata = {{(DATA_W-1){1'b0}}, en_q};
        else                             cfg_rdata = '0;
    end

    // R8
    // ctrl_write_chk
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ctrl_hit) |=> (en_q == $past(cfg_wdata[0])));
    // R2
    // en_reset_chk
    en_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!en_q && phys_addr[OFF_W +: DATA_W] == DEFAULT_PPN));
    // R3
    // disabled_default_chk: holds across a cycle with no enable write
    disabled_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !(cfg_we && ctrl_hit)) |=> (phys_addr[OFF_W +: DATA_W] == DEFAULT_PPN));
endmodule

// File: tb/tb_task_page_mapper.sv
module tb_task_page_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        irq_take = 1'b0, rti_done = 1'b0;
    logic [1:0]  dma_phase = '0;
    logic        cfg_tbl = 1'b0, cfg_we = 1'b0;
    logic [10:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [19:0] phys_addr;
    logic        wp_flag;

    int checks = 0, failures = 0, cyc = 0;

    logic [7:0] m_mem [2048];
    logic [7:0] m_slot [4];
    logic       m_en = 1'b0;
    logic       m_ctx = 1'b0;

    always #5 clk = ~clk;

    task_page_mapper dut (.*);

    function automatic int sel_slot(input logic [1:0] dp, input logic ctx);
        if (dp == 2'b01) return 2;
        if (dp == 2'b10) return 3;
        return ctx ? 1 : 0;
    endfunction

    function automatic logic [7:0] exp_ppn();
        logic [7:0] t = m_slot[sel_slot(dma_phase, m_ctx)];
        return m_en ? m_mem[{t[6:0], cpu_addr[15:12]}] : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_rd();
        if (cfg_tbl) return m_mem[cfg_addr];
        if (cfg_addr < 4) return m_slot[cfg_addr[1:0]];
        if (cfg_addr == 4) return {7'b0, m_en};
        return 8'h00;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // combinational checks in the current cycle
    task automatic check_now();
        string tg;
        tg = !m_en ? "R3 default page" : (dma_phase inside {2'b01, 2'b10}) ? "R7 dma slot page" : "R4 table page";
        chk(phys_addr[11:0] == cpu_addr[11:0], "R1 offset", phys_addr[11:0], cpu_addr[11:0]);
        chk(phys_addr[19:12] == exp_ppn(), tg, phys_addr[19:12], exp_ppn());
        chk(wp_flag == m_slot[sel_slot(dma_phase, m_ctx)][7], "R10 wp_flag", wp_flag,
            m_slot[sel_slot(dma_phase, m_ctx)][7]);
        chk(cfg_rdata == exp_rd(), "R8 R9 readback", cfg_rdata, exp_rd());
    endtask

    // check, clock once, update model, return at falling edge
    task automatic step(input bit do_check);
        #1;
        if (do_check) check_now();
        @(posedge clk);
        #1;
        cyc++;
        if (!rst_n) begin
            m_en = 0; m_ctx = 0;
            for (int i = 0; i < 4; i++) m_slot[i] = 8'h00;
        end else begin
            if (cfg_we) begin
                if (cfg_tbl) m_mem[cfg_addr] = cfg_wdata;
                else if (cfg_addr < 4) m_slot[cfg_addr[1:0]] = cfg_wdata;
                else if (cfg_addr == 4) m_en = cfg_wdata[0];
            end
            if (irq_take) m_ctx = 0;
            else if (rti_done) m_ctx = 1;
        end
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic tbl, input logic [10:0] a, input logic [7:0] d);
        cfg_tbl = tbl; cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        step(1'b0);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        repeat (3) step(1'b0);
        rst_n = 1'b1;
        // R2: reset state through the ports
        for (int s = 0; s < 5; s++) begin
            cfg_tbl = 0; cfg_addr = 11'(s); cpu_addr = 16'($urandom);
            #1;
            chk(cfg_rdata == 8'h00, "R2 reset register", cfg_rdata, 8'h00);
            chk(phys_addr == {8'hFF, cpu_addr[11:0]}, "R2 reset phys", phys_addr, {8'hFF, cpu_addr[11:0]});
            #1;
        end
        step(1'b1);
        // fill the table while disabled; translation stays at default (R3)
        for (int i = 0; i < 2048; i++) begin
            cpu_addr = 16'($urandom);
            #1;
            chk(phys_addr[19:12] == 8'hFF, "R3 disabled during fill", phys_addr[19:12], 8'hFF);
            cfg_write(1'b1, 11'(i), 8'($urandom));
        end
        cfg_write(1'b0, 11'd0, 8'h05);
        cfg_write(1'b0, 11'd1, 8'h83);
        cfg_write(1'b0, 11'd2, 8'h12);
        cfg_write(1'b0, 11'd3, 8'hFF);
        // R3: still disabled after slots are set
        cfg_tbl = 1'b0; cfg_addr = 11'd4; step(1'b1);
        cfg_write(1'b0, 11'd4, 8'h01);
        // R6 then R5: rti selects user, simultaneous irq+rti keeps system
        rti_done = 1; step(1'b1); rti_done = 0;
        cfg_addr = 11'd1; step(1'b1);
        chk(wp_flag == 1'b1, "R6 user slot active", wp_flag, 1'b1);
        irq_take = 1; rti_done = 1; step(1'b1); irq_take = 0; rti_done = 0;
        #1;
        chk(wp_flag == 1'b0, "R5 R6 irq wins", wp_flag, 1'b0);
        step(1'b1);
        // R7: DMA override in the same cycle for each phase
        for (int p = 0; p < 4; p++) begin
            dma_phase = 2'(p); cpu_addr = 16'hA5C3; step(1'b1);
        end
        dma_phase = 0;
        // R8: writes to unused control addresses change nothing
        cfg_write(1'b0, 11'd5, 8'hAA);
        cfg_write(1'b0, 11'd7, 8'h55);
        for (int s = 0; s < 8; s++) begin
            cfg_tbl = 0; cfg_addr = 11'(s); step(1'b1);
        end
        // R9: table write seen in translation the next cycle
        cpu_addr = 16'h3123;
        cfg_write(1'b1, {7'h05, 4'h3}, 8'h9E);
        #1;
        chk(phys_addr == 20'h9E123, "R9 write then translate", phys_addr, 20'h9E123);
        // constrained random mix
        for (int n = 0; n < 6000; n++) begin
            cpu_addr  = 16'($urandom);
            irq_take  = ($urandom % 10) == 0;
            rti_done  = ($urandom % 8) == 0;
            dma_phase = 2'($urandom);
            cfg_tbl   = ($urandom % 2) == 0;
            cfg_addr  = cfg_tbl ? 11'($urandom) : 11'($urandom % 8);
            cfg_we    = ($urandom % 4) == 0;
            if (!cfg_tbl && cfg_addr == 4) cfg_we = ($urandom % 8) == 0;
            cfg_wdata = 8'($urandom);
            if (!cfg_tbl && cfg_addr == 4 && ($urandom % 2) == 0) cfg_wdata[0] = 1'b1;
            step(1'b1);
        end
        cfg_we = 0; irq_take = 0; rti_done = 0;
        step(1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule